// File: doc/BRIEF.md
# Comma-Aligning Receive Framer with Ready Strobe

This block sits behind a clock-recovery stage and runs on the recovered bit clock. It shifts the serial stream through a 10-bit window. When asked to reframe, it hunts for the K28.5 comma in either running disparity and moves the character boundary onto the comma it finds. From then on it hands out one 10-bit character per 10 bit clocks, with a character-rate clock and a flag that marks comma characters.

An active-low ready strobe tells the downstream logic what is on the output. While the block hunts, ready stays high and the character clock is held low, so that clock period stretches and never shortens. The aligned comma is the first character presented after lock, and it always gets a ready pulse. After that, the mode input picks the behaviour. In encoded mode every character gets a pulse, except a comma that is directly followed by another comma, so a run of commas is reported once, on its last member. In unencoded mode only comma characters get a pulse. Deciding whether a comma is the last of a run needs one character of lookahead, so the output trails the detection window by one character.

The controller has three states:
- ST_SEARCH: hunting for a comma, with the character counter frozen.
- ST_LOCK: a comma has been found and sits in the lookahead register.
- ST_RUN: normal presentation.

Its transitions are:
- SEARCH to LOCK when the window holds a comma.
- LOCK to RUN at the end of the next character.
- RUN to SEARCH at the end of a character when a latched reframe request is pending.
- Reset enters SEARCH.

Top module: `comma_framer`

## Requirements
- R1: During and right after reset, rdy_n is 1, char_clk is 0, char_out is 0 and comma_flag is 0. The block starts in the searching state.
- R2: The first bit received is the MSB of a character. A comma is 10'b0011111010 or 10'b1100000101. When the last comma bit is taken on bit-clock edge p+9, the comma appears on char_out from edge p+20. The following characters appear every 10 edges on the new grid, in stream order.
- R3: Outside a search, char_clk is high for 5 bit clocks and then low for 5, and it rises on the edge that updates char_out. No char_clk period is shorter than 10 bit clocks.
- R4: While searching, rdy_n stays 1, char_clk stays 0 and char_out holds its value.
- R5: The first aligned comma is presented with rdy_n low for the first 6 bit clocks of its period, in either mode and whatever follows it.
- R6: With unencoded=0, each presented character drives rdy_n low for its first 6 bit clocks and high for its last 4. The exception is a comma whose next character is also a comma: rdy_n stays high for that one.
- R7: With unencoded=1, rdy_n goes low (first 6 bit clocks) only for comma characters.
- R8: comma_flag is 1 exactly while char_out holds one of the two comma codes.
- R9: realign_req is sampled only on the edge where char_clk falls. If it was 1 there, the search starts when the current character ends. A pulse that misses that edge has no effect. In the character period between lock and the aligned comma, char_out shows the lookahead character from the old grid, and rdy_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data, one bit per clock |
| realign_req | input | 1 | Request to hunt for a new comma boundary |
| unencoded | input | 1 | 1 selects comma-only ready pulses, 0 selects per-character pulses |
| char_out | output | 10 | Aligned character, first bit received in the MSB |
| comma_flag | output | 1 | char_out holds a K28.5 |
| char_clk | output | 1 | Character-rate clock, high for the first half of each period |
| rdy_n | output | 1 | Active-low ready strobe |

## Verification
The assertions assume that unencoded changes only while the block is searching, because a mode change in the middle of a pulse would break the rule that every unencoded pulse belongs to a comma. They also assume that the serial stream contains no false comma straddling a boundary. The stimulus keeps within both limits: the mode is toggled only during a search window, and filler bits are drawn at random with any run of four equal bits forced to break. Commas carry the only five-bit runs, so a sliding window can match only at a real comma.

// File: rtl/cf_pkg.sv
package cf_pkg;

    localparam int CHAR_W = 10;
    localparam logic [CHAR_W-1:0] COMMA_NEG = 10'b0011111010;
    localparam logic [CHAR_W-1:0] COMMA_POS = 10'b1100000101;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_LOCK   = 2'd1,
        ST_RUN    = 2'd2
    } cf_state_e;

    function automatic logic is_comma(input logic [CHAR_W-1:0] v);
        return (v == COMMA_NEG) || (v == COMMA_POS);
    endfunction

endpackage

// File: rtl/cf_window.sv
module cf_window #(
    parameter int W = cf_pkg::CHAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    output logic [W-1:0] win,
    output logic         win_is_k
);

    logic [W-1:0] sh_q;

    // newest bit enters at the LSB, so the oldest bit sits in the MSB
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[W-2:0], ser_in};
    end

    assign win      = sh_q;
    assign win_is_k = cf_pkg::is_comma(sh_q);

endmodule

// File: rtl/cf_phase.sv
module cf_phase #(
    parameter int PERIOD   = 10,
    parameter int HIGH_LEN = 5,
    parameter int CW       = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          restart,
    output logic [CW-1:0] cnt,
    output logic          at_end,
    output logic          fall_next,
    output logic          char_clk
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
    localparam logic [CW-1:0] FALL = CW'(HIGH_LEN - 1);
    localparam logic [CW-1:0] HI   = CW'(HIGH_LEN);

    logic [CW-1:0] cnt_q;

    // reset parks the counter at the last slot, so char_clk starts low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= LAST;
        else if (restart)         cnt_q <= '0;
        else if (!hold) begin
            if (cnt_q == LAST)    cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt       = cnt_q;
    assign at_end    = (cnt_q == LAST);
    assign fall_next = (cnt_q == FALL);
    assign char_clk  = (cnt_q < HI);

endmodule

// File: rtl/comma_framer.sv
module comma_framer #(
    parameter int RDY_LOW  = 6,
    parameter int CLK_HIGH = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ser_in,
    input  logic                      realign_req,
    input  logic                      unencoded,
    output logic [cf_pkg::CHAR_W-1:0] char_out,
    output logic                      comma_flag,
    output logic                      char_clk,
    output logic                      rdy_n
);
    import cf_pkg::*;

    localparam int PERIOD = CHAR_W;
    localparam int CW     = $clog2(PERIOD);
    localparam logic [CW-1:0] LOW_C = CW'(RDY_LOW);

    logic [CHAR_W-1:0] win;
    logic              win_is_k;
    logic [CW-1:0]     cnt;
    logic              at_end, fall_next;
    logic              hold, restart, load, clr_req;
    logic              pulse_q, pulse_nxt;
    logic              req_lat;
    logic [CHAR_W-1:0] look_q, out_q;
    logic              kflag_q, look_k;
    cf_state_e         state, state_nxt;

    cf_window #(.W(CHAR_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .win      (win),
        .win_is_k (win_is_k)
    );

    cf_phase #(.PERIOD(PERIOD), .HIGH_LEN(CLK_HIGH), .CW(CW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .restart   (restart),
        .cnt       (cnt),
        .at_end    (at_end),
        .fall_next (fall_next),
        .char_clk  (char_clk)
    );

    assign look_k = is_comma(look_q);

    // next state and datapath controls
    always_comb begin
        state_nxt = state;
        hold      = 1'b0;
        restart   = 1'b0;
        load      = 1'b0;
        clr_req   = 1'b0;
        pulse_nxt = pulse_q;
        unique case (state)
            ST_SEARCH: begin
                if (win_is_k) begin
                    state_nxt = ST_LOCK;
                    restart   = 1'b1;
                    load      = 1'b1;
                    pulse_nxt = 1'b0;
                end else begin
                    hold = 1'b1;
                end
            end
            ST_LOCK: begin
                if (at_end) begin
                    state_nxt = ST_RUN;
                    load      = 1'b1;
                    pulse_nxt = 1'b1;
                end
            end
            ST_RUN: begin
                if (at_end) begin
                    if (req_lat) begin
                        state_nxt = ST_SEARCH;
                        hold      = 1'b1;
                        clr_req   = 1'b1;
                        pulse_nxt = 1'b0;
                    end else begin
                        load      = 1'b1;
                        pulse_nxt = unencoded ? look_k : !(look_k && win_is_k);
                    end
                end
            end
            default: state_nxt = ST_SEARCH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SEARCH;
        else        state <= state_nxt;
    end

    // character pipeline, ready decision and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            look_q  <= '0;
            out_q   <= '0;
            kflag_q <= 1'b0;
            pulse_q <= 1'b0;
            req_lat <= 1'b0;
        end else begin
            if (load) begin
                look_q  <= win;
                out_q   <= look_q;
                kflag_q <= look_k;
            end
            pulse_q <= pulse_nxt;
            if (clr_req)        req_lat <= 1'b0;
            else if (fall_next) req_lat <= realign_req;
        end
    end

    // outputs
    always_comb begin
        char_out   = out_q;
        comma_flag = kflag_q;
        rdy_n      = !(pulse_q && (cnt < LOW_C));
    end

endmodule

// File: rtl/cf_checks.sv
module cf_checks #(
    parameter int CHAR_W = cf_pkg::CHAR_W
) (
    input logic              clk,
    input logic              rst_n,
    input cf_pkg::cf_state_e state,
    input logic              char_clk,
    input logic              rdy_n,
    input logic [CHAR_W-1:0] char_out,
    input logic              comma_flag,
    input logic              unencoded
);

    logic              clk_d;
    logic [CHAR_W-1:0] out_d;
    int                gap;
    logic              rise;

    assign rise = char_clk && !clk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_d <= 1'b0;
            out_d <= '0;
            gap   <= CHAR_W;
        end else begin
            clk_d <= char_clk;
            out_d <= char_out;
            if (rise)            gap <= 1;
            else if (gap < CHAR_W) gap <= gap + 1;
        end
    end

    assert_min_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (gap >= CHAR_W));

    assert_out_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (char_out != out_d) |-> rise);

    assert_search_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == cf_pkg::ST_SEARCH) |-> (rdy_n && !char_clk));

    assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $rose(char_clk));

    assert_unenc_comma_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unencoded && !rdy_n) |-> comma_flag);

    assert_flag_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        comma_flag == cf_pkg::is_comma(char_out));

endmodule

bind comma_framer cf_checks #(.CHAR_W(cf_pkg::CHAR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .char_clk   (char_clk),
    .rdy_n      (rdy_n),
    .char_out   (char_out),
    .comma_flag (comma_flag),
    .unencoded  (unencoded)
);

// File: tb/comma_framer_test.sv
module comma_framer_test;

    localparam int LEN = 2000;
    localparam int NCH = 60;
    localparam int M   = NCH - 6;
    localparam int IGN = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       realign_req = 1'b0;
    logic       unencoded = 1'b0;
    logic [9:0] char_out;
    logic       comma_flag, char_clk, rdy_n;

    int  total = 0;
    int  bad   = 0;
    int  cur_t = 0;
    bit  done  = 1'b0;
    bit  bits [0:LEN-1];
    int  csel [0:LEN-1];
    int  P [0:2];
    bit  UNENC [0:2];

    always #4 clk = ~clk;

    comma_framer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .realign_req (realign_req),
        .unencoded   (unencoded),
        .char_out    (char_out),
        .comma_flag  (comma_flag),
        .char_clk    (char_clk),
        .rdy_n       (rdy_n)
    );

    function automatic logic [9:0] chr(input int pos);
        logic [9:0] v;
        for (int i = 0; i < 10; i++) v[9-i] = (pos + i < LEN) ? bits[pos+i] : 1'b0;
        return v;
    endfunction

    function automatic bit isk(input logic [9:0] v);
        return (v == 10'b0011111010) || (v == 10'b1100000101);
    endfunction

    task automatic expect_eq(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s t=%0d actual=%0h expected=%0h", tag, what, cur_t, act, exp);
        end
    endtask

    task automatic build_stream();
        int i, run, pick;
        bit last, b;
        logic [9:0] pat;
        int unsigned junk;
        junk = $urandom(32'd97531);
        for (int x = 0; x < LEN; x++) csel[x] = 0;
        for (int j = 0; j < 3; j++) begin
            csel[P[j]] = 1 + int'($urandom % 2);
            for (int k = 1; k < M; k++) begin
                pick = int'($urandom % 100);
                if (k == 5 || k == 6 || k == 7 || k == 12 || (j == 0 && k == 1) || pick < 35)
                    csel[P[j] + 10*k] = 1 + int'($urandom % 2);
            end
        end
        i = 0; run = 0; last = 1'b0;
        while (i < LEN) begin
            if (csel[i] != 0) begin
                pat = (csel[i] == 1) ? 10'b0011111010 : 10'b1100000101;
                for (int q = 0; q < 10; q++) begin
                    b = pat[9-q];
                    if (i + q < LEN) bits[i+q] = b;
                    if (b == last) run++; else begin run = 1; last = b; end
                end
                i += 10;
            end else begin
                b = bit'($urandom % 2);
                if (run >= 4 && b == last) b = !last;
                bits[i] = b;
                if (b == last) run++; else begin run = 1; last = b; end
                i++;
            end
        end
    endtask

    task automatic check_cycle(input int t);
        logic [9:0] e_out;
        logic e_clk, e_rdy, pulse;
        string tag_rdy, tag_out;
        int k, ph;
        cur_t = t;
        e_out = '0; e_clk = 1'b0; e_rdy = 1'b1;
        tag_rdy = "R4"; tag_out = "R4";
        for (int j = 0; j < 3; j++) begin
            if (j > 0 && t >= P[j-1] + 30 + 10*M && t < P[j] + 10) begin
                e_out = chr(P[j-1] + 10*M); e_clk = 1'b0; e_rdy = 1'b1;
                tag_rdy = "R4"; tag_out = "R4";
            end
            if (t >= P[j] + 10 && t < P[j] + 20) begin
                ph = t - P[j] - 10;
                e_out = (j == 0) ? 10'd0 : chr(P[j-1] + 10*(M+1));
                e_clk = (ph < 5); e_rdy = 1'b1;
                tag_rdy = "R9"; tag_out = "R9";
            end
            if (t >= P[j] + 20 && (j == 2 || t < P[j] + 30 + 10*M)) begin
                k  = (t - P[j] - 20) / 10;
                ph = (t - P[j] - 20) % 10;
                e_out = chr(P[j] + 10*k);
                e_clk = (ph < 5);
                if (k == 0)         pulse = 1'b1;
                else if (UNENC[j])  pulse = isk(e_out);
                else                pulse = !(isk(e_out) && isk(chr(P[j] + 10*(k+1))));
                e_rdy = !(pulse && ph < 6);
                tag_rdy = (k == 0) ? "R5" : (UNENC[j] ? "R7" : "R6");
                tag_out = "R2";
            end
        end
        expect_eq(tag_rdy, "rdy_n", int'(rdy_n), int'(e_rdy));
        expect_eq("R3", "char_clk", int'(char_clk), int'(e_clk));
        expect_eq(tag_out, "char_out", int'(char_out), int'(e_out));
        expect_eq("R8", "comma_flag", int'(comma_flag), int'(isk(e_out)));
    endtask

    function automatic bit req_at(input int t);
        for (int j = 0; j < 2; j++) begin
            if (t >= P[j] + 20 + 10*M && t <= P[j] + 28 + 10*M) return 1'b1;
            // R9: pulse that straddles a boundary but misses the falling edge
            if (t >= P[j] + 26 + 10*IGN && t <= P[j] + 32 + 10*IGN) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic bit mode_at(input int t);
        return (t >= P[0] + 30 + 10*M) && (t < P[1] + 30 + 10*M);
    endfunction

    initial begin
        P[0] = 37;
        P[1] = P[0] + 10*NCH + 13;
        P[2] = P[1] + 10*NCH + 27;
        UNENC[0] = 1'b0; UNENC[1] = 1'b1; UNENC[2] = 1'b0;
        build_stream();
        repeat (3) @(negedge clk);
        // R1: reset values
        expect_eq("R1", "rdy_n", int'(rdy_n), 1);
        expect_eq("R1", "char_clk", int'(char_clk), 0);
        expect_eq("R1", "char_out", int'(char_out), 0);
        expect_eq("R1", "comma_flag", int'(comma_flag), 0);
        ser_in = bits[0];
        rst_n  = 1'b1;
        for (int t = 0; t < LEN; t++) begin
            @(negedge clk);
            check_cycle(t);
            if (t + 1 < LEN) ser_in = bits[t+1];
            realign_req = req_at(t);
            unencoded   = mode_at(t);
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (LEN + 500) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule